// File: doc/BRIEF.md
# Descriptor-Table Scatter-Gather Walker

This block is the bus-master engine of a storage DMA channel. A device-side buffer holds a known number of bytes. These bytes must be moved to or from host memory regions that are listed in a descriptor table, which also lives in host memory. After a start pulse, the walker reads 8-byte descriptors one at a time from the table base onwards. It then carves each region into bounded bursts and issues them on a request/acknowledge data port. It stops when the buffer has been fully moved (`done`) or when the table has nothing more to offer (`exhausted`).

A descriptor carries the region address in its low 32-bit word. Its high word carries the size and an end-of-table flag. The length field has an even granularity, and a zero length stands for a full 64 KiB region. The table is also bounded: after 4 KiB of descriptors the walker gives up even when no end flag has been seen. This guards against a table in memory that was never terminated.

The controller has six states. `W_IDLE` is the reset state and waits for a start. `W_EVAL` decides the next step: it goes to `W_DONE` when no buffer bytes remain. If the current region is empty, it goes to `W_EXHAUST` when the end flag was consumed or the page limit is reached, and otherwise to `W_FETCH`. If the region still holds bytes, it goes to `W_MOVE`. `W_FETCH` requests a descriptor and returns to `W_EVAL` on its acknowledge. `W_MOVE` requests one burst and returns to `W_EVAL` on its acknowledge. `W_DONE` and `W_EXHAUST` hold until the next start. A start in any state jumps to `W_EVAL` with fresh state.

Top module: `prd_walker`

## Requirements
- R1: After reset, `desc_req`, `xfer_req`, `done` and `exhausted` are all low, and no request is raised until `start` is pulsed.
- R2: A fetched descriptor supplies the region address in `desc_rdata[31:0]` and the size word in `desc_rdata[63:32]`. The region length is `size & 0xFFFE`, so size bit 0 has no effect on the length.
- R3: A length field of zero (after masking) describes a region of 65536 bytes.
- R4: Size bit 31 marks the final descriptor. Once that region is used up, no further descriptor is fetched. If buffer bytes still remain, `exhausted` rises and `done` stays low.
- R5: Descriptors are fetched at `table_base + 8*k` for k = 0, 1, 2 and so on. At most 4096/8 = 512 descriptors are fetched per run, and after that the run ends with `exhausted` if buffer bytes remain.
- R6: Each burst moves min(buffer bytes left, region bytes left, 256) bytes. Successive bursts within a region have contiguous addresses, starting at the region address.
- R7: When the buffer count reaches zero, `done` rises, even if the table ended at that same point. A `byte_count` of 0 gives `done` with no fetch and no burst.
- R8: `xfer_write` equals the `to_host` value that was sampled with `start`: 1 means the data is written to host memory, and 0 means it is read from host memory.
- R9: `start` restarts the walker from any state. In the cycle after `start`, `done` and `exhausted` are low, any request that was in flight is abandoned, and the next fetch is at `table_base`.
- R10: Once raised, a request (`desc_req` or `xfer_req`) is held with stable address and length until its acknowledge arrives, unless `start` intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start/restart pulse; samples base, count and direction |
| to_host | input | 1 | 1 = buffer to host memory, 0 = host memory to buffer |
| table_base | input | 32 | Byte address of the first descriptor |
| byte_count | input | CNT_W | Bytes to move for this run |
| desc_req | output | 1 | Descriptor read request |
| desc_addr | output | 32 | Byte address of the descriptor requested |
| desc_ack | input | 1 | Descriptor read acknowledge; `desc_rdata` is valid with it |
| desc_rdata | input | 64 | Descriptor: [31:0] region address, [63:32] size word |
| xfer_req | output | 1 | Data burst request |
| xfer_write | output | 1 | Burst direction, 1 = write to host memory |
| xfer_addr | output | 32 | Host address of the burst |
| xfer_len | output | LEN_W | Burst length in bytes, 1 to MAX_BURST |
| xfer_ack | input | 1 | Burst completion acknowledge |
| done | output | 1 | Buffer fully moved; held until next start |
| exhausted | output | 1 | Table ran out first; held until next start |

## Verification
The hardest condition to reach is the page safety stop. It takes a table of more than 512 descriptors with no end flag, and a byte count larger than those regions add up to. The bench fills such a table with tiny 2-byte regions, so that 512 fetches happen within a few thousand cycles. It then runs it twice: once with a count that ends exactly at the 512th region (the buffer must win), and once with a larger count (the table limit must win). A restart in the middle of a run is also set up deliberately. The bench raises `start` while a request is outstanding and withholds the acknowledge in that cycle. It then expects the full burst sequence again from the table base.

// File: rtl/prd_walker_pkg.sv
package prd_walker_pkg;

    typedef enum logic [2:0] {
        W_IDLE,
        W_EVAL,
        W_FETCH,
        W_MOVE,
        W_DONE,
        W_EXHAUST
    } walk_state_e;

    localparam int DESC_BYTES  = 8;
    localparam int RGN_LEN_W   = 17;
    localparam int ADDR_W      = 32;

endpackage

// File: rtl/prd_desc_unpack.sv
module prd_desc_unpack
    import prd_walker_pkg::*;
(
    input  logic [63:0]          raw,
    output logic [ADDR_W-1:0]    rgn_addr,
    output logic [RGN_LEN_W-1:0] rgn_len,
    output logic                 rgn_last
);
    logic [15:0] masked_len;
    logic        unused_bits;

    always_comb begin
        rgn_addr   = raw[31:0];
        masked_len = {raw[47:33], 1'b0};
        rgn_len    = (masked_len == 16'd0) ? RGN_LEN_W'(17'h10000)
                                           : {1'b0, masked_len};
        rgn_last   = raw[63];
    end

    assign unused_bits = ^{raw[62:48], raw[32]};

endmodule

// File: rtl/prd_burst_size.sv
module prd_burst_size
    import prd_walker_pkg::*;
#(
    parameter int CNT_W     = 20,
    parameter int MAX_BURST = 256,
    parameter int LEN_W     = $clog2(MAX_BURST) + 1
) (
    input  logic [CNT_W-1:0]     buf_left,
    input  logic [RGN_LEN_W-1:0] rgn_left,
    output logic [LEN_W-1:0]     burst
);
    logic [31:0] a_w, b_w, m_w, ab_w;

    always_comb begin
        a_w   = 32'(buf_left);
        b_w   = 32'(rgn_left);
        m_w   = 32'(MAX_BURST);
        ab_w  = (a_w < b_w) ? a_w : b_w;
        burst = LEN_W'((ab_w < m_w) ? ab_w : m_w);
    end

endmodule

// File: rtl/prd_table_ptr.sv
module prd_table_ptr
    import prd_walker_pkg::*;
#(
    parameter int TABLE_LIMIT = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic              advance,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              at_limit
);
    localparam int OFF_W = $clog2(TABLE_LIMIT) + 1;

    logic [ADDR_W-1:0] base_q;
    logic [OFF_W-1:0]  off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            off_q  <= '0;
        end else if (reload) begin
            base_q <= base;
            off_q  <= '0;
        end else if (advance) begin
            off_q  <= off_q + OFF_W'(DESC_BYTES);
        end
    end

    assign fetch_addr = base_q + ADDR_W'(off_q);
    assign at_limit   = (32'(off_q) >= 32'(TABLE_LIMIT));

    // R5
    page_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !reload) |-> !at_limit);

endmodule

// File: rtl/prd_walker.sv
module prd_walker
    import prd_walker_pkg::*;
#(
    parameter int CNT_W       = 20,
    parameter int MAX_BURST   = 256,
    parameter int TABLE_LIMIT = 4096,
    parameter int LEN_W       = $clog2(MAX_BURST) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              to_host,
    input  logic [31:0]       table_base,
    input  logic [CNT_W-1:0]  byte_count,
    output logic              desc_req,
    output logic [31:0]       desc_addr,
    input  logic              desc_ack,
    input  logic [63:0]       desc_rdata,
    output logic              xfer_req,
    output logic              xfer_write,
    output logic [31:0]       xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    input  logic              xfer_ack,
    output logic              done,
    output logic              exhausted
);
    walk_state_e state_q, state_d;

    logic [CNT_W-1:0]     buf_left_q;
    logic [ADDR_W-1:0]    rgn_addr_q;
    logic [RGN_LEN_W-1:0] rgn_left_q;
    logic                 rgn_last_q;
    logic                 dir_q;

    logic [ADDR_W-1:0]    new_addr;
    logic [RGN_LEN_W-1:0] new_len;
    logic                 new_last;
    logic [LEN_W-1:0]     burst;
    logic                 at_limit;
    logic                 fetch_taken;
    logic                 move_taken;

    prd_desc_unpack u_unpack (
        .raw      (desc_rdata),
        .rgn_addr (new_addr),
        .rgn_len  (new_len),
        .rgn_last (new_last)
    );

    prd_burst_size #(
        .CNT_W     (CNT_W),
        .MAX_BURST (MAX_BURST),
        .LEN_W     (LEN_W)
    ) u_size (
        .buf_left (buf_left_q),
        .rgn_left (rgn_left_q),
        .burst    (burst)
    );

    assign fetch_taken = (state_q == W_FETCH) && desc_ack && !start;
    assign move_taken  = (state_q == W_MOVE)  && xfer_ack && !start;

    prd_table_ptr #(
        .TABLE_LIMIT (TABLE_LIMIT)
    ) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload     (start),
        .advance    (fetch_taken),
        .base       (table_base),
        .fetch_addr (desc_addr),
        .at_limit   (at_limit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE:    state_d = W_IDLE;
            W_EVAL: begin
                if (buf_left_q == '0)                    state_d = W_DONE;
                else if (rgn_left_q == '0) begin
                    if (rgn_last_q || at_limit)          state_d = W_EXHAUST;
                    else                                 state_d = W_FETCH;
                end else                                 state_d = W_MOVE;
            end
            W_FETCH:   if (desc_ack) state_d = W_EVAL;
            W_MOVE:    if (xfer_ack) state_d = W_EVAL;
            W_DONE:    state_d = W_DONE;
            W_EXHAUST: state_d = W_EXHAUST;
            default:   state_d = W_IDLE;
        endcase
        if (start) state_d = W_EVAL;
    end

    // walker data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_left_q <= '0;
            rgn_addr_q <= '0;
            rgn_left_q <= '0;
            rgn_last_q <= 1'b0;
            dir_q      <= 1'b0;
        end else if (start) begin
            buf_left_q <= byte_count;
            rgn_addr_q <= '0;
            rgn_left_q <= '0;
            rgn_last_q <= 1'b0;
            dir_q      <= to_host;
        end else if (fetch_taken) begin
            rgn_addr_q <= new_addr;
            rgn_left_q <= new_len;
            rgn_last_q <= new_last;
        end else if (move_taken) begin
            rgn_addr_q <= rgn_addr_q + ADDR_W'(burst);
            rgn_left_q <= rgn_left_q - RGN_LEN_W'(burst);
            buf_left_q <= buf_left_q - CNT_W'(burst);
        end
    end

    // outputs
    always_comb begin
        desc_req   = (state_q == W_FETCH);
        xfer_req   = (state_q == W_MOVE);
        xfer_write = dir_q;
        xfer_addr  = rgn_addr_q;
        xfer_len   = burst;
        done       = (state_q == W_DONE);
        exhausted  = (state_q == W_EXHAUST);
    end

    // R6
    burst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> (xfer_len != '0 && 32'(xfer_len) <= MAX_BURST
                      && CNT_W'(xfer_len) <= buf_left_q));

    // R10
    xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack && !start) |=>
            (xfer_req && $stable(xfer_addr) && $stable(xfer_len)));

    // R10
    desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_req && !desc_ack && !start) |=> (desc_req && $stable(desc_addr)));

    // R9
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && !exhausted && !desc_req && !xfer_req));

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

endmodule

// File: tb/prd_walker_bench.sv
module prd_walker_bench;
    localparam int CNT_W = 20;
    localparam int LEN_W = 9;
    localparam int TBL_N = 520;
    localparam int LOG_N = 1024;
    localparam logic [31:0] BASE = 32'h0001_0000;

    logic clk = 0, rst_n = 0, start = 0, to_host = 0;
    logic [31:0] table_base = BASE;
    logic [CNT_W-1:0] byte_count = '0;
    logic desc_req, desc_ack = 0, xfer_req, xfer_write, xfer_ack = 0, done, exhausted;
    logic [31:0] desc_addr, xfer_addr;
    logic [63:0] desc_rdata = '0;
    logic [LEN_W-1:0] xfer_len;

    always #10 clk = ~clk;

    prd_walker u_prd_walker (.*);

    logic [31:0] t_addr [0:TBL_N-1];
    logic [31:0] t_size [0:TBL_N-1];
    int exp_a [0:LOG_N-1];
    int exp_l [0:LOG_N-1];
    int lg_a  [0:LOG_N-1];
    int lg_l  [0:LOG_N-1];
    int n_exp, n_log, n_fetch, bad_fetch, bad_dir, exp_fetch;
    bit exp_done, cur_dir, stall;
    int n_chk = 0, n_fail = 0, cyc = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // memory responder: acts on falling edges only
    always @(negedge clk) begin
        cyc++;
        if (!rst_n || start) begin
            desc_ack = 0;
            xfer_ack = 0;
        end else begin
            stall = ~stall;
            if (desc_req && !desc_ack && !stall) begin
                int idx;
                if (n_fetch == 0 && desc_addr != table_base) bad_fetch++;
                idx = int'((desc_addr - table_base) >> 3);
                if (idx != n_fetch || idx >= TBL_N) begin
                    bad_fetch++;
                    idx = 0;
                end
                desc_rdata = {t_size[idx], t_addr[idx]};
                desc_ack = 1;
                n_fetch++;
            end else desc_ack = 0;
            if (xfer_req && !xfer_ack && !stall) begin
                if (n_log < LOG_N) begin
                    lg_a[n_log] = int'(xfer_addr);
                    lg_l[n_log] = int'(xfer_len);
                end
                if (xfer_write != cur_dir) bad_dir++;
                n_log++;
                xfer_ack = 1;
            end else xfer_ack = 0;
        end
    end

    always @(posedge clk) if (cyc > 190000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    function automatic void ref_walk(input int nbytes);
        int rem, k, cl, ca, l;
        bit last;
        rem = nbytes; k = 0; cl = 0; ca = 0; last = 0; n_exp = 0;
        forever begin
            if (rem == 0) begin exp_done = 1; break; end
            if (cl == 0) begin
                if (last || k * 8 >= 4096) begin exp_done = 0; break; end
                ca = int'(t_addr[k]);
                cl = int'(t_size[k] & 32'h0000_FFFE);
                if (cl == 0) cl = 65536;
                last = t_size[k][31];
                k++;
            end
            l = (rem < cl) ? rem : cl;
            if (l > 256) l = 256;
            if (n_exp < LOG_N) begin exp_a[n_exp] = ca; exp_l[n_exp] = l; end
            n_exp++;
            ca += l; cl -= l; rem -= l;
        end
        exp_fetch = k;
    endfunction

    task automatic launch(input int nbytes, input bit dir);
        @(posedge clk); #2;
        start = 1; byte_count = CNT_W'(nbytes); to_host = dir; cur_dir = dir;
        n_log = 0; n_fetch = 0; bad_fetch = 0; bad_dir = 0;
        @(posedge clk); #2;
        start = 0;
        n_log = 0; n_fetch = 0; bad_fetch = 0; bad_dir = 0;
        check(!done && !exhausted, "R9 flags clear after start", int'(done | exhausted), 0);
    endtask

    task automatic finish_run(input int nbytes, input string tag);
        int waited = 0;
        bit ok;
        ref_walk(nbytes);
        while (!done && !exhausted && waited < 80000) begin
            @(negedge clk); waited++;
        end
        check(done == exp_done && exhausted == !exp_done,
              exp_done ? "R7 done outcome" : "R4 exhausted outcome",
              int'(done), int'(exp_done));
        ok = (n_log == n_exp);
        for (int i = 0; i < n_exp && i < LOG_N && ok; i++)
            if (lg_a[i] != exp_a[i] || lg_l[i] != exp_l[i]) begin
                ok = 0;
                $display("  %s burst %0d addr %h/%h len %0d/%0d", tag, i,
                         lg_a[i], exp_a[i], lg_l[i], exp_l[i]);
            end
        check(ok, "R6 burst sequence", n_log, n_exp);
        check(n_fetch == exp_fetch, "R5 fetch count", n_fetch, exp_fetch);
        check(bad_fetch == 0, "R9 fetch addresses from base", bad_fetch, 0);
        check(bad_dir == 0, "R8 direction", bad_dir, 0);
    endtask

    task automatic run(input int nbytes, input bit dir, input string tag);
        launch(nbytes, dir);
        finish_run(nbytes, tag);
    endtask

    task automatic clear_table();
        for (int i = 0; i < TBL_N; i++) begin
            t_addr[i] = 32'h0;
            t_size[i] = 32'h8000_0002;
        end
    endtask

    initial begin
        stall = 0; cur_dir = 0;
        n_log = 0; n_fetch = 0; bad_fetch = 0; bad_dir = 0;
        clear_table();
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(!desc_req && !xfer_req && !done && !exhausted, "R1 reset outputs",
              int'({desc_req, xfer_req, done, exhausted}), 0);

        // single region split into bursts
        t_addr[0] = 32'h2000_0000; t_size[0] = 32'h8000_0258;
        run(600, 1, "single");
        run(100, 0, "partial");

        // R2 size bit 0 ignored, two regions
        t_addr[0] = 32'h3000_0010; t_size[0] = 32'h0000_0101;
        t_addr[1] = 32'h4000_0000; t_size[1] = 32'h8000_0064;
        run(356, 0, "R2 odd size");
        check(n_log > 0 && lg_l[0] == 256 && lg_a[1] == 32'h4000_0000,
              "R2 length masked", n_log > 0 ? lg_l[0] : 0, 256);
        // R4 table ends before buffer
        run(1000, 1, "R4 short table");

        // R3 zero length means 64 KiB
        t_addr[0] = 32'h5000_0000; t_size[0] = 32'h8000_0000;
        run(65536, 1, "R3 full");
        run(70000, 0, "R3 over");

        // R7 zero byte count
        run(0, 1, "R7 empty");
        check(n_fetch == 0 && n_log == 0, "R7 no activity", n_fetch + n_log, 0);

        // R5 page limit with unterminated table
        for (int i = 0; i < TBL_N; i++) begin
            t_addr[i] = 32'h6000_0000 + 32'(i * 256);
            t_size[i] = 32'h0000_0002;
        end
        run(1024, 1, "R5 exact");
        run(5000, 0, "R5 over");

        // R9 restart in the middle of a run
        launch(5000, 1);
        repeat (37) @(negedge clk);
        run(5000, 1, "R9 restarted");

        // sweep over three-region table
        clear_table();
        t_addr[0] = 32'h7000_0100; t_size[0] = 32'h0000_012C;
        t_addr[1] = 32'h7100_0000; t_size[1] = 32'h0000_0003;
        t_addr[2] = 32'h7200_0040; t_size[2] = 32'h8000_01FE;
        for (int n = 0; n <= 820; n += 13) run(n, n[0], "sweep");
        run(812, 0, "sweep exact");
        run(813, 1, "sweep over");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule